// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Interrupts

This block manages a bank of general-purpose pins through a 32-bit register bus. The bus has a byte address, separate write and read strobes, write data and read data. For every pin, the block works out the level seen on the pad. An external driver takes precedence. If there is none, the block's own output is used when it is enabled. If neither applies, the pull-up setting decides the level. The output path has a polarity-invert mask, so firmware can flip individual pins without rewriting the level register.

On every clock edge, each pin's pad level is gated by its input enable and captured into a read-only sample register. That sample is compared with the previous one. Four sticky pending masks are kept per pin: level high, level low, rising edge and falling edge. Each mask is cleared by writing ones to it. Every pin has its own interrupt line, formed from its pending bits and the matching enable bits. A separate sticky vector records each pin that drove its output while an external driver was also active.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The internal output of a pin is out_en AND (out_lvl XOR out_inv), using the registers at 0x08, 0x0C and 0x40.
- R2: `pad_out[i]` follows this priority. `ext_level[i]` is used when `ext_valid[i]` is 1. Otherwise the internal output is used when out_en is 1. Otherwise the pull-up bit at 0x10 is used.
- R3: At each clock edge, the sample register (offset 0x00, read-only) captures in_en (0x04) AND the pad value. A change in configuration therefore shows up in the sample one edge after the write edge.
- R4: High-pending (0x2C) sets while a pin's sample is 1. Low-pending (0x34) sets while the sample is 0, which includes pins whose input is disabled. Both are sticky.
- R5: Rise-pending (0x1C) sets when the new sample is 1 and the stored sample is 0. Fall-pending (0x24) sets on the opposite change.
- R6: A write to a pending register clears each bit where the data is 1 and leaves the other bits alone. If a set condition occurs in the same cycle, the set wins.
- R7: `irq[i]` is the OR over the four kinds of pending AND enable. The enables are rise 0x18, fall 0x20, high 0x28 and low 0x30.
- R8: The registers at 0x04–0x18, 0x20, 0x28, 0x30, 0x38, 0x3C and 0x40 read back what was written. The registers at 0x14, 0x38 and 0x3C are storage only. `bus_rdata` is 0 while `bus_rd` is low.
- R9: A read from an offset above 0x40 returns 0. A write to such an offset, or to 0x00, changes no register.
- R10: `short_flag[i]` sets one edge after out_en[i] and `ext_valid[i]` are both 1. Only reset clears it.
- R11: Reset clears every register, every pending bit, the sample register and `short_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address; bits [1:0] ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ext_valid | input | 32 | Pin driven from outside |
| ext_level | input | 32 | Level of the outside driver |
| pad_out | output | 32 | Resolved pad level |
| irq | output | 32 | Interrupt line per pin |
| short_flag | output | 32 | Sticky contention record |

## Verification
Two things can hit the same pending bit on the same edge: a write-1-to-clear from software and a set condition produced by the sampled input. The bench creates this by holding a pin high and then clearing its high-pending bit. The bit must read back as 1. Clearing the rise-pending bit while the input is steady must read back 0. The bench also clears the low-pending bits while one pin is high and another pin has its input disabled. Only the disabled pin must stay pending.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_W    = 32;
    localparam int NREG     = 17;
    localparam int N_KIND   = 4;
    // word indices; event registers pair enable/pending per kind
    localparam int IX_SAMPLE  = 0;
    localparam int IX_IN_EN   = 1;
    localparam int IX_OUT_EN  = 2;
    localparam int IX_OUT_LVL = 3;
    localparam int IX_PULL    = 4;
    localparam int IX_DRV     = 5;
    localparam int IX_EVT     = 6;   // enable at IX_EVT+2k, pending at +1
    localparam int IX_ALT_EN  = 14;
    localparam int IX_ALT_SEL = 15;
    localparam int IX_OUT_INV = 16;
    // kind order fixes the event register layout
    localparam int K_RISE = 0;
    localparam int K_FALL = 1;
    localparam int K_HIGH = 2;
    localparam int K_LOW  = 3;
endpackage

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve #(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0] ext_valid,
    input  logic [NPIN-1:0] ext_level,
    input  logic [NPIN-1:0] out_en,
    input  logic [NPIN-1:0] out_lvl,
    input  logic [NPIN-1:0] out_inv,
    input  logic [NPIN-1:0] pull_en,
    input  logic [NPIN-1:0] in_en,
    output logic [NPIN-1:0] pad,
    output logic [NPIN-1:0] sample
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic drive_bit;
        assign drive_bit = out_en[i] & (out_lvl[i] ^ out_inv[i]);
        always_comb begin
            if (ext_valid[i])   pad[i] = ext_level[i];
            else if (out_en[i]) pad[i] = drive_bit;
            else                pad[i] = pull_en[i];
        end
        assign sample[i] = in_en[i] & pad[i];
    end
endmodule

// File: rtl/gpio_pend_next.sv
module gpio_pend_next #(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0] pend_q,
    input  logic [NPIN-1:0] set_v,
    input  logic [NPIN-1:0] clr_v,
    output logic [NPIN-1:0] pend_d
);
    // set after clear: a fresh event survives a simultaneous clear
    assign pend_d = (pend_q & ~clr_v) | set_v;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_irq_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int IDX_W = 5
) (
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           idx,
    input  logic [NREG-1:0][NPIN-1:0]  regs,
    output logic [BUS_W-1:0]           data
);
    always_comb begin
        data = '0;
        if (rd_en) begin
            for (int r = 0; r < NREG; r++) begin
                if (idx == IDX_W'(r)) data[NPIN-1:0] = regs[r];
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   ext_valid,
    input  logic [NPIN-1:0]   ext_level,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   irq,
    output logic [NPIN-1:0]   short_flag
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [NPIN-1:0]               smp;
        logic [NPIN-1:0]               in_en;
        logic [NPIN-1:0]               out_en;
        logic [NPIN-1:0]               out_lvl;
        logic [NPIN-1:0]               pull_en;
        logic [NPIN-1:0]               drv_str;
        logic [NPIN-1:0]               alt_en;
        logic [NPIN-1:0]               alt_sel;
        logic [NPIN-1:0]               out_inv;
        logic [N_KIND-1:0][NPIN-1:0]   ien;
        logic [N_KIND-1:0][NPIN-1:0]   pend;
        logic [NPIN-1:0]               short_seen;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]              widx;
    logic [NREG-1:0]               wr_sel;
    logic [NPIN-1:0]               wdat;
    logic [NPIN-1:0]               sample;
    logic [N_KIND-1:0][NPIN-1:0]   set_v, clr_v, pend_nxt;
    logic [NREG-1:0][NPIN-1:0]     rd_view;
    logic [1:0]                    unused_lsb;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = bus_addr[1:0];
    assign wdat       = bus_wdata[NPIN-1:0];

    // write decode; the sample register never accepts a write
    always_comb begin
        wr_sel = '0;
        for (int r = 1; r < NREG; r++) begin
            wr_sel[r] = bus_wr && (widx == IDX_W'(r));
        end
    end

    gpio_pad_resolve #(.NPIN(NPIN)) u_pad (
        .ext_valid (ext_valid),
        .ext_level (ext_level),
        .out_en    (st_q.out_en),
        .out_lvl   (st_q.out_lvl),
        .out_inv   (st_q.out_inv),
        .pull_en   (st_q.pull_en),
        .in_en     (st_q.in_en),
        .pad       (pad_out),
        .sample    (sample)
    );

    assign set_v[K_RISE] =  sample & ~st_q.smp;
    assign set_v[K_FALL] = ~sample &  st_q.smp;
    assign set_v[K_HIGH] =  sample;
    assign set_v[K_LOW]  = ~sample;

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        assign clr_v[k] = wr_sel[IX_EVT + 2*k + 1] ? wdat : '0;
        gpio_pend_next #(.NPIN(NPIN)) u_pend (
            .pend_q (st_q.pend[k]),
            .set_v  (set_v[k]),
            .clr_v  (clr_v[k]),
            .pend_d (pend_nxt[k])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_sel[IX_IN_EN])   st_d.in_en   = wdat;
        if (wr_sel[IX_OUT_EN])  st_d.out_en  = wdat;
        if (wr_sel[IX_OUT_LVL]) st_d.out_lvl = wdat;
        if (wr_sel[IX_PULL])    st_d.pull_en = wdat;
        if (wr_sel[IX_DRV])     st_d.drv_str = wdat;
        if (wr_sel[IX_ALT_EN])  st_d.alt_en  = wdat;
        if (wr_sel[IX_ALT_SEL]) st_d.alt_sel = wdat;
        if (wr_sel[IX_OUT_INV]) st_d.out_inv = wdat;
        for (int k = 0; k < N_KIND; k++) begin
            if (wr_sel[IX_EVT + 2*k]) st_d.ien[k] = wdat;
        end
        st_d.pend       = pend_nxt;
        st_d.smp        = sample;
        st_d.short_seen = st_q.short_seen | (st_q.out_en & ext_valid);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        irq = '0;
        for (int k = 0; k < N_KIND; k++) irq |= st_q.pend[k] & st_q.ien[k];
    end

    always_comb begin
        rd_view             = '0;
        rd_view[IX_SAMPLE]  = st_q.smp;
        rd_view[IX_IN_EN]   = st_q.in_en;
        rd_view[IX_OUT_EN]  = st_q.out_en;
        rd_view[IX_OUT_LVL] = st_q.out_lvl;
        rd_view[IX_PULL]    = st_q.pull_en;
        rd_view[IX_DRV]     = st_q.drv_str;
        rd_view[IX_ALT_EN]  = st_q.alt_en;
        rd_view[IX_ALT_SEL] = st_q.alt_sel;
        rd_view[IX_OUT_INV] = st_q.out_inv;
        for (int k = 0; k < N_KIND; k++) begin
            rd_view[IX_EVT + 2*k]     = st_q.ien[k];
            rd_view[IX_EVT + 2*k + 1] = st_q.pend[k];
        end
    end

    gpio_rd_mux #(.NPIN(NPIN), .IDX_W(IDX_W)) u_rd (
        .rd_en (bus_rd),
        .idx   (widx),
        .regs  (rd_view),
        .data  (bus_rdata)
    );

    assign short_flag = st_q.short_seen;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NPIN-1:0]   ext_valid,
    input logic [NPIN-1:0]   ext_level,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   short_flag,
    input logic [NPIN-1:0]   out_en,
    input logic [NPIN-1:0]   high_pend
);
    localparam int IDX_W = ADDR_W - 2;

    // R2: an outside driver always decides the pad
    a_r2_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ ext_level) & ext_valid) == '0);

    // R8: read data is quiet without a read strobe
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

    // R10: contention record never drops a bit
    a_r10_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(short_flag) & ~short_flag) == '0);

    // R10: contention is recorded on the next edge
    a_r10_short_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(out_en & ext_valid) & ~short_flag) == '0);

    // R4: high-pending only falls through a write to its own register
    a_r4_high_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[ADDR_W-1:2] == IDX_W'(IX_EVT + 2*K_HIGH + 1))
        |=> ($past(high_pend) & ~high_pend) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .ext_valid  (ext_valid),
    .ext_level  (ext_level),
    .pad_out    (pad_out),
    .short_flag (short_flag),
    .out_en     (st_q.out_en),
    .high_pend  (st_q.pend[2])
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic        bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_valid = '0;
    logic [31:0] ext_level = '0;
    logic [31:0] pad_out, irq, short_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_valid(ext_valid), .ext_level(ext_level), .pad_out(pad_out),
        .irq(irq), .short_flag(short_flag)
    );

    typedef struct packed {
        logic [31:0] ev, el, oe, lvl, inv, pull, exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0000FFFF, 32'h0000FFFF},
        '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h00FF00FF, 32'h0F0F0F0F, 32'h0, 32'h0FF00FF0},
        '{32'hFFFF0000, 32'hAAAAAAAA, 32'h0000FFFF, 32'h12345678, 32'h0, 32'h0, 32'hAAAA5678},
        '{32'h000000FF, 32'h0, 32'h00000F00, 32'hFFFFFFFF, 32'h00000300, 32'hFFFF0000, 32'hFFFF0C00}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        // R11 reset state
        idle(3);
        for (int r = 0; r < 17; r++) begin
            rd(7'(r * 4), d);
            chk("R11 reset register", d, 32'h0);
        end
        #1;
        chk("R11 reset pad", pad_out, 32'h0);
        chk("R11 reset irq", irq, 32'h0);
        chk("R11 reset short", short_flag, 32'h0);
        @(negedge clk) rst_n = 1;

        // table: pad resolution (R1 R2) and sampling (R3)
        wr(7'h04, 32'hFFFFFFFF);
        for (int v = 0; v < 4; v++) begin
            wr(7'h08, VECS[v].oe);
            wr(7'h0C, VECS[v].lvl);
            wr(7'h40, VECS[v].inv);
            wr(7'h10, VECS[v].pull);
            @(negedge clk);
            ext_valid = VECS[v].ev; ext_level = VECS[v].el;
            #1 chk("R1 R2 pad vector", pad_out, VECS[v].exp);
            idle(1);
            rd(7'h00, d);
            chk("R3 sample vector", d, VECS[v].exp);
        end
        chk("R10 no contention in table", short_flag, 32'h0);
        @(negedge clk);
        ext_valid = '0; ext_level = '0;

        // R8 storage registers and read-back
        wr(7'h14, 32'hA5A5_0F0F);
        wr(7'h38, 32'h1357_9BDF);
        wr(7'h3C, 32'hFEDC_BA98);
        rd(7'h14, d); chk("R8 drive-strength storage", d, 32'hA5A5_0F0F);
        rd(7'h38, d); chk("R8 alt-enable storage", d, 32'h1357_9BDF);
        rd(7'h3C, d); chk("R8 alt-select storage", d, 32'hFEDC_BA98);
        rd(7'h40, d); chk("R8 invert read-back", d, VECS[3].inv);

        // R9 unmapped and read-only
        wr(7'h04, 32'h0);
        idle(2);
        wr(7'h00, 32'hFFFFFFFF);
        rd(7'h00, d); chk("R9 sample ignores write", d, 32'h0);
        wr(7'h44, 32'hFFFFFFFF);
        rd(7'h44, d); chk("R9 unmapped read", d, 32'h0);
        rd(7'h7C, d); chk("R9 top unmapped read", d, 32'h0);
        rd(7'h14, d); chk("R9 unmapped write harmless", d, 32'hA5A5_0F0F);

        // pending behaviour on pin 0; pin 1 has input disabled
        wr(7'h40, 32'h0);
        wr(7'h10, 32'h0);
        wr(7'h0C, 32'h0);
        wr(7'h08, 32'h1);
        wr(7'h04, 32'h1);
        idle(2);
        wr(7'h1C, 32'hFFFFFFFF);
        wr(7'h24, 32'hFFFFFFFF);
        wr(7'h2C, 32'hFFFFFFFF);
        rd(7'h1C, d); chk("R6 rise cleared", d & 1, 0);
        rd(7'h2C, d); chk("R6 high cleared", d & 1, 0);
        rd(7'h34, d); chk("R4 low pending while 0", d & 1, 1);
        wr(7'h0C, 32'h1);
        idle(2);
        rd(7'h1C, d); chk("R5 rise on 0->1", d & 1, 1);
        rd(7'h24, d); chk("R5 no fall on 0->1", d & 1, 0);
        rd(7'h2C, d); chk("R4 high pending while 1", d & 1, 1);
        rd(7'h00, d); chk("R3 sample follows pad", d, 32'h1);
        wr(7'h1C, 32'h1);
        rd(7'h1C, d); chk("R6 rise clears when steady", d & 1, 0);
        wr(7'h2C, 32'h1);
        rd(7'h2C, d); chk("R6 set wins over clear", d & 1, 1);
        wr(7'h34, 32'hFFFFFFFF);
        rd(7'h34, d); chk("R4 R6 low: pin0 clear, disabled pin1 stays", d & 3, 2);
        wr(7'h28, 32'h1);
        #1 chk("R7 high enable raises irq", irq, 32'h1);
        wr(7'h28, 32'h0);
        wr(7'h30, 32'h1);
        #1 chk("R7 enable without pending", irq, 32'h0);
        wr(7'h30, 32'h2);
        #1 chk("R7 low irq on disabled pin", irq, 32'h2);
        wr(7'h30, 32'h0);
        wr(7'h0C, 32'h0);
        idle(2);
        rd(7'h24, d); chk("R5 fall on 1->0", d & 1, 1);
        rd(7'h1C, d); chk("R5 no rise on 1->0", d & 1, 0);
        wr(7'h20, 32'h1);
        #1 chk("R7 fall irq", irq, 32'h1);
        wr(7'h04, 32'h0);
        wr(7'h0C, 32'h1);
        idle(2);
        rd(7'h00, d); chk("R3 input disabled samples 0", d, 32'h0);

        // R10 contention, R2 outside driver wins
        wr(7'h08, 32'h20);
        wr(7'h0C, 32'h20);
        @(negedge clk);
        ext_valid = 32'h20; ext_level = 32'h0;
        #1 chk("R2 outside driver beats output", pad_out & 32'h20, 32'h0);
        idle(1);
        #1 chk("R10 contention flagged", short_flag, 32'h20);
        @(negedge clk) ext_valid = '0;
        idle(3);
        #1 chk("R10 flag sticky", short_flag, 32'h20);
        #1 chk("R2 output drives when released", pad_out & 32'h20, 32'h20);

        // R11 reset clears the record
        @(negedge clk) rst_n = 0;
        idle(2);
        #1 chk("R11 reset clears short", short_flag, 32'h0);
        chk("R11 reset clears irq", irq, 32'h0);
        @(negedge clk) rst_n = 1;
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule